// File: doc/BRIEF.md
# Video Receive Size Gate

This block sits between the decoded output of an HDMI receiver and the stream port of a frame-writing DMA engine. It accepts 16-bit 4:2:2 luma/chroma pixels qualified by a data-enable and framed by a vertical sync, and produces 24-bit RGB pixels on a valid-only stream marked with start-of-frame and end-of-line flags. Everything runs on the receiver's pixel clock.

While the frame arrives, the block counts the pixels in every active line and counts the active lines. At the next frame boundary it compares those numbers with the programmed width and height. The next frame is forwarded only if the frame just finished had exactly the expected size. Any other frame is suppressed in full. A DMA engine that was set up for one byte count therefore never receives a frame of another size, and cannot lock up waiting for bytes that do not come. A sticky flag records that a mismatch occurred. Software clears it with a one-cycle pulse.

The normal path repeats each chroma sample across its pixel pair and converts the result to RGB with fixed-point studio-range coefficients. A bypass setting forwards the raw 16-bit input word instead, with zeros above it.

Top module: `vrx_size_gate`

## Requirements
- R1: After reset, `m_valid`, `m_sof`, `m_eol` and `mismatch` are all low.
- R2: A frame runs from one rising edge of `in_vsync` to the next. Its width is the length of each high run of `in_de`, and its height is the number of such runs. The frame matches only when every run equals `cfg_width` and the run count equals `cfg_height` and is non-zero.
- R3: A frame is forwarded if and only if the frame that immediately preceded it matched. The forwarding decision changes only on a rising edge of `in_vsync`. No beat is produced for a suppressed frame.
- R4: The first frame after reset is never forwarded. The boundary that opens it raises no mismatch, because no earlier frame has been measured.
- R5: `mismatch` goes high on the rising edge of `in_vsync` that closes a non-matching frame, and it stays high. A one-cycle `clr_mismatch` pulse clears it. If a clear and a new mismatch fall in the same cycle, the new mismatch wins.
- R6: `in_data[7:0]` carries luma and `in_data[15:8]` carries chroma. Counting from 0 at the start of each line, even pixels carry Cb and odd pixels carry Cr. Both pixels of a pair use that pair's Cb and Cr. If a line ends on an even pixel, that pixel uses its own chroma as both Cb and Cr.
- R7: When `cfg_bypass` is low, `m_data` is {R,G,B}, with R in bits 23:16 and B in bits 7:0. With y=Y-16, u=Cb-128 and v=Cr-128, the values are R=(298y+409v+128)>>8, G=(298y-100u-208v+128)>>8 and B=(298y+516u+128)>>8. The shift is arithmetic, and each result is clamped to 0..255.
- R8: When `cfg_bypass` is high, `m_data` is {8'h00, in_data} of the same pixel.
- R9: `m_sof` is high on the first forwarded pixel of a frame. `m_eol` is high on the last pixel of each line. Both are low whenever `m_valid` is low.
- R10: Every pixel of a forwarded frame appears once, in input order. A pixel sampled at clock edge t appears on the outputs after edge t+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the receiver |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vsync | input | 1 | Vertical sync; its rising edge marks a frame boundary |
| in_de | input | 1 | Active-pixel qualifier |
| in_data | input | 16 | Chroma in bits 15:8, luma in bits 7:0 |
| cfg_width | input | DIM_W | Expected active pixels per line |
| cfg_height | input | DIM_W | Expected active lines per frame |
| cfg_bypass | input | 1 | Forward raw input instead of RGB |
| clr_mismatch | input | 1 | One-cycle pulse that clears the mismatch flag |
| m_valid | output | 1 | Output pixel valid; the sink accepts every beat |
| m_data | output | 24 | RGB pixel, or zero-extended raw word in bypass |
| m_sof | output | 1 | First pixel of a forwarded frame |
| m_eol | output | 1 | Last pixel of a line |
| mismatch | output | 1 | Sticky size-mismatch flag |

## Verification
The hardest case to reach is a frame whose height is correct but whose width is wrong on one interior line only. Frame-level stimulus does not produce it. The driver can shorten any single line of a frame. The bench sends such a frame and then checks two things: the following correctly sized frame is suppressed entirely, and the flag rises at that frame's boundary. The same alternating pattern of correct, wrong and correct frames exercises the one-frame lag of the decision for width errors, height errors and the first frame after reset. It also exercises clear pulses placed between the mismatches.

// File: rtl/vrx_pkg.sv
// Package: shared constants, pixel record and helpers for the video
// receive size gate. Assumes 8-bit components and a 16-bit 4:2:2 input word.
package vrx_pkg;

    localparam int COMP_W = 8;
    localparam int RAW_W  = 2 * COMP_W;
    localparam int RGB_W  = 3 * COMP_W;
    localparam int ACC_W  = 20;

    // Fixed-point colour coefficients scaled by 256.
    localparam logic signed [ACC_W-1:0] K_Y   = 20'sd298;
    localparam logic signed [ACC_W-1:0] K_RV  = 20'sd409;
    localparam logic signed [ACC_W-1:0] K_GU  = 20'sd100;
    localparam logic signed [ACC_W-1:0] K_GV  = 20'sd208;
    localparam logic signed [ACC_W-1:0] K_BU  = 20'sd516;
    localparam logic signed [ACC_W-1:0] K_RND = 20'sd128;

    typedef struct packed {
        logic              sof;
        logic              eol;
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] cb;
        logic [COMP_W-1:0] cr;
        logic [RAW_W-1:0]  raw;
    } vrx_pix_t;

    // Saturate a signed accumulator to one 8-bit component.
    function automatic logic [COMP_W-1:0] sat_comp(input logic signed [ACC_W-1:0] v);
        if (v < 0)
            return '0;
        else if (v > 20'sd255)
            return '1;
        else
            return v[COMP_W-1:0];
    endfunction

endpackage

// File: rtl/vrx_size_meter.sv
// Module: measures the active width and height of each frame and decides at
// every vsync rising edge whether the next frame may pass. Also keeps the
// sticky mismatch flag. Assumes in_de is low around the vsync edge.
module vrx_size_meter #(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vsync,
    input  logic             in_de,
    input  logic [DIM_W-1:0] cfg_width,
    input  logic [DIM_W-1:0] cfg_height,
    input  logic             clr_mismatch,
    output logic             frame_start,
    output logic             gate_open,
    output logic             mismatch
);

    localparam logic [DIM_W-1:0] CNT_MAX = '1;

    logic             vs_d, de_d;
    logic             seen_q, bad_w_q, gate_q, sticky_q;
    logic [DIM_W-1:0] px_cnt, ln_cnt;
    logic             vs_rise, de_fall, frame_ok, mism_evt;

    assign vs_rise  = in_vsync & ~vs_d;
    assign de_fall  = de_d & ~in_de;
    assign frame_ok = seen_q & ~bad_w_q & (ln_cnt == cfg_height) & (ln_cnt != '0);
    assign mism_evt = vs_rise & seen_q & ~frame_ok;

    // Edge history for vsync and data-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_d <= 1'b0;
            de_d <= 1'b0;
        end else begin
            vs_d <= in_vsync;
            de_d <= in_de;
        end
    end

    // Pixel counter within the current active line, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            px_cnt <= '0;
        else if (in_de)
            px_cnt <= !de_d ? DIM_W'(1) : ((px_cnt == CNT_MAX) ? px_cnt : px_cnt + 1'b1);
    end

    // Line counter and width-error flag, restarted at every frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_cnt  <= '0;
            bad_w_q <= 1'b0;
        end else if (vs_rise) begin
            ln_cnt  <= '0;
            bad_w_q <= 1'b0;
        end else if (de_fall) begin
            ln_cnt  <= (ln_cnt == CNT_MAX) ? ln_cnt : ln_cnt + 1'b1;
            bad_w_q <= bad_w_q | (px_cnt != cfg_width);
        end
    end

    // Frame-boundary decision: open the gate for the next frame only after a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            gate_q <= 1'b0;
        end else if (vs_rise) begin
            seen_q <= 1'b1;
            gate_q <= frame_ok;
        end
    end

    // Sticky mismatch flag; a new mismatch beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky_q <= 1'b0;
        else if (mism_evt)
            sticky_q <= 1'b1;
        else if (clr_mismatch)
            sticky_q <= 1'b0;
    end

    assign frame_start = vs_rise;
    assign gate_open   = gate_q;
    assign mismatch    = sticky_q;

    // The forwarding decision moves only at a frame boundary.
    assert_gate_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_q) |-> $past(vs_rise));

    // The first boundary after reset keeps the gate closed.
    assert_first_frame_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise && !seen_q) |=> !gate_q);

    // The flag rises only at a measured frame boundary.
    assert_sticky_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_q) |-> $past(vs_rise && seen_q));

    // A clear with no competing boundary empties the flag.
    assert_sticky_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mismatch && !vs_rise) |=> !sticky_q);

endmodule

// File: rtl/vrx_chroma_up.sv
// Module: turns the 4:2:2 stream into 4:4:4 pixel records. It repeats each
// pair's Cb and Cr on both pixels, and tags start-of-frame, end-of-line and the gate.
// Assumes Cb on even and Cr on odd pixels, counted from each line start.
module vrx_chroma_up
    import vrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_de,
    input  logic [RAW_W-1:0] in_data,
    input  logic             frame_start,
    input  logic             gate_open,
    output logic             o_vld,
    output vrx_pix_t         o_pix
);

    logic              sof_pend;
    logic              r1_de, r1_odd, r1_sof, r1_gate;
    logic [COMP_W-1:0] r1_y, r1_c, r2_c;
    logic [RAW_W-1:0]  r1_raw;
    logic              cur_odd;
    logic [COMP_W-1:0] in_c;

    assign cur_odd = in_de & r1_de & ~r1_odd;
    assign in_c    = in_data[RAW_W-1:COMP_W];

    // Pending start-of-frame mark, consumed by the first active pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sof_pend <= 1'b0;
        else if (frame_start)
            sof_pend <= 1'b1;
        else if (in_de)
            sof_pend <= 1'b0;
    end

    // First stage: hold one pixel so that its pair partner can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_de   <= 1'b0;
            r1_odd  <= 1'b0;
            r1_sof  <= 1'b0;
            r1_gate <= 1'b0;
            r1_y    <= '0;
            r1_c    <= '0;
            r2_c    <= '0;
            r1_raw  <= '0;
        end else begin
            r1_de   <= in_de;
            r1_odd  <= cur_odd;
            r1_sof  <= in_de & sof_pend;
            r1_gate <= gate_open;
            r1_y    <= in_data[COMP_W-1:0];
            r1_c    <= in_c;
            r2_c    <= r1_c;
            r1_raw  <= in_data;
        end
    end

    // Second stage: assemble the full pixel with both chroma samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld <= 1'b0;
            o_pix <= '0;
        end else begin
            o_vld     <= r1_de & r1_gate;
            o_pix.sof <= r1_de & r1_gate & r1_sof;
            o_pix.eol <= r1_de & r1_gate & ~in_de;
            o_pix.y   <= r1_y;
            o_pix.raw <= r1_raw;
            if (r1_odd) begin
                o_pix.cb <= r2_c;
                o_pix.cr <= r1_c;
            end else begin
                o_pix.cb <= r1_c;
                o_pix.cr <= in_de ? in_c : r1_c;
            end
        end
    end

    // An odd pixel always follows an even active pixel of the same line.
    assert_pair_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r1_de && r1_odd) |-> $past(r1_de && !r1_odd));

endmodule

// File: rtl/vrx_csc.sv
// Module: converts 4:4:4 luma/chroma records to RGB with studio-range
// fixed-point coefficients, or forwards the raw word in bypass, and registers
// the output stream. Assumes bypass changes only between frames.
module vrx_csc
    import vrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             i_vld,
    input  vrx_pix_t         i_pix,
    output logic             m_valid,
    output logic [RGB_W-1:0] m_data,
    output logic             m_sof,
    output logic             m_eol
);

    logic signed [9:0]       ys, us, vs;
    logic signed [ACC_W-1:0] ye, ue, ve;
    logic signed [ACC_W-1:0] r_sum, g_sum, b_sum;
    logic signed [ACC_W-1:0] r_sh, g_sh, b_sh;
    logic [COMP_W-1:0]       r_c, g_c, b_c;

    // Offset-removed components, colour sums and saturation.
    always_comb begin
        ys    = $signed({2'b00, i_pix.y})  - 10'sd16;
        us    = $signed({2'b00, i_pix.cb}) - 10'sd128;
        vs    = $signed({2'b00, i_pix.cr}) - 10'sd128;
        ye    = {{(ACC_W-10){ys[9]}}, ys};
        ue    = {{(ACC_W-10){us[9]}}, us};
        ve    = {{(ACC_W-10){vs[9]}}, vs};
        r_sum = ye * K_Y + ve * K_RV + K_RND;
        g_sum = ye * K_Y - ue * K_GU - ve * K_GV + K_RND;
        b_sum = ye * K_Y + ue * K_BU + K_RND;
        r_sh  = r_sum >>> 8;
        g_sh  = g_sum >>> 8;
        b_sh  = b_sum >>> 8;
        r_c   = sat_comp(r_sh);
        g_c   = sat_comp(g_sh);
        b_c   = sat_comp(b_sh);
    end

    // Output register: converted or raw pixel with framing flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_sof   <= 1'b0;
            m_eol   <= 1'b0;
            m_data  <= '0;
        end else begin
            m_valid <= i_vld;
            m_sof   <= i_pix.sof;
            m_eol   <= i_pix.eol;
            m_data  <= bypass ? {{COMP_W{1'b0}}, i_pix.raw} : {r_c, g_c, b_c};
        end
    end

    // Framing flags appear only on valid beats.
    assert_marks_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_sof || m_eol) |-> m_valid);

    // A bypassed beat carries zeros above the raw word.
    assert_bypass_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && $past(bypass)) |-> (m_data[RGB_W-1:RAW_W] == '0));

endmodule

// File: rtl/vrx_size_gate.sv
// Module: top of the video receive size gate. It measures each frame,
// forwards the next frame only after a matching one, upsamples chroma and
// converts to RGB. Assumes a sink that accepts every beat on the pixel clock.
module vrx_size_gate
    import vrx_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vsync,
    input  logic             in_de,
    input  logic [15:0]      in_data,
    input  logic [DIM_W-1:0] cfg_width,
    input  logic [DIM_W-1:0] cfg_height,
    input  logic             cfg_bypass,
    input  logic             clr_mismatch,
    output logic             m_valid,
    output logic [23:0]      m_data,
    output logic             m_sof,
    output logic             m_eol,
    output logic             mismatch
);

    logic     frame_start, gate_open;
    logic     up_vld;
    vrx_pix_t up_pix;

    vrx_size_meter #(.DIM_W(DIM_W)) i_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_vsync     (in_vsync),
        .in_de        (in_de),
        .cfg_width    (cfg_width),
        .cfg_height   (cfg_height),
        .clr_mismatch (clr_mismatch),
        .frame_start  (frame_start),
        .gate_open    (gate_open),
        .mismatch     (mismatch)
    );

    vrx_chroma_up i_up (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_de       (in_de),
        .in_data     (in_data),
        .frame_start (frame_start),
        .gate_open   (gate_open),
        .o_vld       (up_vld),
        .o_pix       (up_pix)
    );

    vrx_csc i_csc (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass  (cfg_bypass),
        .i_vld   (up_vld),
        .i_pix   (up_pix),
        .m_valid (m_valid),
        .m_data  (m_data),
        .m_sof   (m_sof),
        .m_eol   (m_eol)
    );

endmodule

// File: tb/test_vrx_size_gate.sv
// Scoreboard bench: the frame driver pushes the expected beats and a monitor
// pops and compares them at every falling edge.
module test_vrx_size_gate;

    localparam int CFG_W = 8;
    localparam int CFG_H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vsync = 1'b0;
    logic        in_de = 1'b0;
    logic [15:0] in_data = '0;
    logic [11:0] cfg_width = 12'(CFG_W);
    logic [11:0] cfg_height = 12'(CFG_H);
    logic        cfg_bypass = 1'b0;
    logic        clr_mismatch = 1'b0;
    logic        m_valid, m_sof, m_eol, mismatch;
    logic [23:0] m_data;

    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;
    bit          have_prev = 1'b0;
    bit          prev_ok = 1'b0;
    bit          exp_sticky = 1'b0;
    logic [25:0] exp_q[$];
    logic [25:0] e;

    always #4 clk = ~clk;

    vrx_size_gate i_vrx_size_gate (
        .clk(clk), .rst_n(rst_n), .in_vsync(in_vsync), .in_de(in_de),
        .in_data(in_data), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_bypass(cfg_bypass), .clr_mismatch(clr_mismatch),
        .m_valid(m_valid), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol),
        .mismatch(mismatch)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] clamp(input int v);
        if (v < 0) return 8'd0;
        if (v > 255) return 8'd255;
        return 8'(v);
    endfunction

    function automatic logic [23:0] to_rgb(input int y, input int cb, input int cr);
        int yy, u, v;
        yy = 298 * (y - 16);
        u  = cb - 128;
        v  = cr - 128;
        return {clamp((yy + 409 * v + 128) >>> 8),
                clamp((yy - 100 * u - 208 * v + 128) >>> 8),
                clamp((yy + 516 * u + 128) >>> 8)};
    endfunction

    // Monitor: compare every output beat with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (m_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "beat from suppressed frame", {8'h0, m_data}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(m_data == e[23:0], cfg_bypass ? "R8" : "R6 R7", "pixel data",
                          {8'h0, m_data}, {8'h0, e[23:0]});
                    check(m_sof == e[25], "R9", "start-of-frame", 32'(m_sof), 32'(e[25]));
                    check(m_eol == e[24], "R9", "end-of-line", 32'(m_eol), 32'(e[24]));
                end
            end else begin
                check(!m_sof && !m_eol, "R9", "flags without valid", {30'h0, m_sof, m_eol}, 32'h0);
            end
        end
    end

    // Drive one frame: vsync pulse, then h lines of w pixels (one line 2 shorter if short_ln >= 0).
    task automatic send_frame(input int h, input int w, input int short_ln,
                              input int fid, input bit byp);
        int  ya[16];
        int  ca[16];
        bit  open;
        bit  ok;
        int  wl;
        int  cb, cr;
        @(negedge clk);
        cfg_bypass = byp;
        open = have_prev && prev_ok;
        if (have_prev && !prev_ok) exp_sticky = 1'b1;
        in_vsync = 1'b1;
        repeat (2) @(negedge clk);
        in_vsync = 1'b0;
        repeat (2) @(negedge clk);
        check(mismatch == exp_sticky, have_prev ? "R5" : "R4", "mismatch flag at boundary",
              32'(mismatch), 32'(exp_sticky));
        repeat (3) @(negedge clk);
        ok = (h == CFG_H);
        for (int l = 0; l < h; l++) begin
            wl = (l == short_ln) ? w - 2 : w;
            if (wl != CFG_W) ok = 1'b0;
            for (int p = 0; p < wl; p++) begin
                ya[p] = (fid * 37 + l * 11 + p * 23 + 20) & 255;
                ca[p] = (fid * 53 + l * 71 + p * 29 + 64) & 255;
            end
            if (open) begin
                for (int p = 0; p < wl; p++) begin
                    if (p % 2 == 0) begin
                        cb = ca[p];
                        cr = (p + 1 < wl) ? ca[p + 1] : ca[p];
                    end else begin
                        cb = ca[p - 1];
                        cr = ca[p];
                    end
                    exp_q.push_back({(l == 0 && p == 0), (p == wl - 1),
                                     byp ? {8'h00, 8'(ca[p]), 8'(ya[p])} : to_rgb(ya[p], cb, cr)});
                end
            end
            for (int p = 0; p < wl; p++) begin
                in_de   = 1'b1;
                in_data = {8'(ca[p]), 8'(ya[p])};
                @(negedge clk);
            end
            in_de = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R10", "beats still missing after frame", 32'(exp_q.size()), 32'h0);
        exp_q.delete();
        have_prev = 1'b1;
        prev_ok   = ok;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr_mismatch = 1'b1;
        @(negedge clk);
        clr_mismatch = 1'b0;
        @(negedge clk);
        exp_sticky = 1'b0;
        check(mismatch == 1'b0, "R5", "flag after clear pulse", 32'(mismatch), 32'h0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    // Main sequence.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!m_valid && !m_sof && !m_eol, "R1", "stream after reset",
              {29'h0, m_valid, m_sof, m_eol}, 32'h0);
        check(mismatch == 1'b0, "R1", "flag after reset", 32'(mismatch), 32'h0);

        send_frame(CFG_H, CFG_W, -1, 0, 1'b0);  // R4: first frame suppressed
        send_frame(CFG_H, CFG_W, -1, 1, 1'b0);  // R3: forwarded after a match
        send_frame(CFG_H, 6, -1, 2, 1'b0);      // R2: narrow, still forwarded
        send_frame(CFG_H, CFG_W, -1, 3, 1'b0);  // R3: suppressed, flag rises
        clear_flag();
        send_frame(3, CFG_W, -1, 4, 1'b0);      // R2: short frame, forwarded
        send_frame(CFG_H, CFG_W, -1, 5, 1'b0);  // suppressed after height error
        clear_flag();
        send_frame(CFG_H, CFG_W, 2, 6, 1'b0);   // R2: one interior line short
        send_frame(CFG_H, CFG_W, -1, 7, 1'b0);  // suppressed after line error
        clear_flag();
        clear_flag();                           // R5: clear with flag already low
        send_frame(CFG_H, CFG_W, -1, 8, 1'b1);  // R8: bypass frame
        send_frame(CFG_H, CFG_W, -1, 9, 1'b0);  // R7: back to conversion
        send_frame(0, CFG_W, -1, 10, 1'b0);     // boundary only, closes frame 9
        finish_run();
    end

endmodule